// File: doc/BRIEF.md
# MIDI Host Port Interrupt Controller

This block is the processor-facing register window of a legacy MIDI interface. The host sees two byte-wide I/O locations. Offset 0 is the data port. Offset 1 reads as status and takes command bytes on writes. Host data writes are placed in a single-byte holding register and leave the block on a valid/ready transmit stream. Bytes from the MIDI receiver come in on a valid/ready receive stream and are queued in a small FIFO. The host drains that FIFO by reading the data port.

A command controller watches writes to offset 1. A reset command (0xFF) always queues an acknowledge byte of 0xFE. A request to enter pass-through UART mode (0x3F) also queues 0xFE, but only when the controller is not already in that mode. The acknowledge bytes share the receive FIFO with MIDI data, so the host reads them through the same path. A single level-sensitive interrupt output is high while the activate bit is set and the FIFO holds at least one byte. Transmit traffic has no effect on the interrupt.

The transmit stream follows standard valid/ready rules. `tx_valid` stays high and `tx_data` holds steady until `tx_ready` completes the handshake. The receive stream shows back-pressure through `rx_ready`. A serial receiver cannot stall, however. A byte presented while `rx_ready` is low is therefore dropped, and a sticky overflow flag is set. `rx_ready` goes low when the FIFO is full. It also goes low in any cycle where a command acknowledge claims the FIFO's single write slot.

Top module: `midi_host_port`

## Requirements
- R1: Status bit 6 reads 1 from an accepted data-port write until the transmit handshake completes, and 0 otherwise. Any host write (data or command) made while it reads 1 is ignored, and `tx_data` holds its value.
- R2: Status bits 5 to 0 always read 0.
- R3: Status bit 7 reads 0 when at least one byte can be read from the data port, and 1 when the receive FIFO is empty.
- R4: A write of 0xFF to offset 1 queues the byte 0xFE into the receive FIFO. It clears `cmd_uart_mode`, and nothing appears on the transmit stream.
- R5: A write of 0x3F to offset 1 while `cmd_uart_mode` is 0 queues 0xFE and sets `cmd_uart_mode`. While `cmd_uart_mode` is 1, writes of 0x3F and any byte other than 0xFF queue nothing.
- R6: Reads of the data port return the queued bytes in arrival order, removing one byte per read.
- R7: `irq` is 1 whenever the activate bit is 1 and the FIFO is not empty. It stays 1 across data-port reads until the read that empties the FIFO, and is 0 in the cycle after that read.
- R8: While the activate bit (loaded from `cfg_activate` when `cfg_we` is 1) is 0, `irq` is 0 whatever the FIFO holds.
- R9: Transmit writes, busy changes and transmit handshakes never change `irq`.
- R10: When the FIFO holds its full depth, `rx_ready` is 0, a byte offered with `rx_valid` is dropped, and `rx_overflow` becomes 1 and stays 1 until reset. `rx_ready` is also 0 in a cycle with an acknowledge-producing command write, and the acknowledge takes the slot.
- R11: After synchronous reset, the FIFO is empty, status reads 0x80, and `irq`, `tx_valid`, `rx_overflow`, `cmd_uart_mode` and the activate bit are all 0.
- R12: A data-port read with the FIFO empty returns 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the data port, 1 selects status/command |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte for the selected location (combinational) |
| cfg_we | input | 1 | Loads the activate bit |
| cfg_activate | input | 1 | New activate bit value |
| irq | output | 1 | Level interrupt request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive slot available |
| rx_data | input | 8 | Receive byte |
| rx_overflow | output | 1 | Sticky dropped-byte flag |
| cmd_uart_mode | output | 1 | Command controller is in pass-through UART mode |

## Verification
The bench builds the block with a receive FIFO depth of 4 instead of the default 16. With that depth the full condition, the dropped fifth byte and the sticky overflow flag are reached after a handful of receive transfers. The pointer wrap is also exercised several times over the run. Reducing the depth does not shorten the acknowledge-priority and interrupt-hold scenarios, which run as they would at full depth.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CMD_RESET   = 8'hFF;
  localparam byte_t CMD_UART_ON = 8'h3F;
  localparam byte_t ACK_BYTE    = 8'hFE;

  typedef enum logic {LOC_DATA = 1'b0, LOC_CTRL = 1'b1} loc_e;
endpackage

// File: rtl/midi_rx_fifo.sv
module midi_rx_fifo
  import midi_port_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  byte_t push_data,
  input  logic  pop,
  output byte_t head,
  output logic  empty,
  output logic  full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  byte_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_pop_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/midi_cmd_ctrl.sv
module midi_cmd_ctrl
  import midi_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd_we,
  input  byte_t cmd_byte,
  output logic  ack_req,
  output logic  uart_mode
);
  logic uart_q;
  logic is_reset, is_uart;

  assign is_reset  = (cmd_byte == CMD_RESET);
  assign is_uart   = (cmd_byte == CMD_UART_ON);
  assign ack_req   = cmd_we && (is_reset || (is_uart && !uart_q));
  assign uart_mode = uart_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      uart_q <= 1'b0;
    end else if (cmd_we) begin
      if (is_reset)     uart_q <= 1'b0;
      else if (is_uart) uart_q <= 1'b1;
    end
  end

  p_uart_enter_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && is_uart && !uart_q) |=> uart_q);
endmodule

// File: rtl/midi_tx_hold.sv
module midi_tx_hold
  import midi_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  byte_t load_data,
  output logic  tx_valid,
  input  logic  tx_ready,
  output byte_t tx_data,
  output logic  busy
);
  logic  full_q;
  byte_t data_q;

  assign tx_valid = full_q;
  assign tx_data  = data_q;
  assign busy     = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!full_q) begin
      if (load) begin
        full_q <= 1'b1;
        data_q <= load_data;
      end
    end else if (tx_ready) begin
      full_q <= 1'b0;
    end
  end

  p_busy_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import midi_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cfg_we,
  input  logic       cfg_activate,
  output logic       irq,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       rx_overflow,
  output logic       cmd_uart_mode
);
  logic  busy, active_q, ovf_q;
  logic  data_rd, data_wr, cmd_wr, ack_req;
  logic  fifo_push, fifo_empty, fifo_full;
  byte_t fifo_in, fifo_head;

  assign data_rd = bus_rd && (loc_e'(bus_addr) == LOC_DATA);
  assign data_wr = bus_wr && (loc_e'(bus_addr) == LOC_DATA) && !busy;
  assign cmd_wr  = bus_wr && (loc_e'(bus_addr) == LOC_CTRL) && !busy;

  midi_cmd_ctrl u_cmd (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (cmd_wr),
    .cmd_byte  (bus_wdata),
    .ack_req   (ack_req),
    .uart_mode (cmd_uart_mode)
  );

  midi_tx_hold u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (data_wr),
    .load_data (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .busy      (busy)
  );

  // Acknowledge bytes own the single FIFO write slot in their cycle.
  assign rx_ready  = !fifo_full && !ack_req;
  assign fifo_push = ack_req || (rx_valid && rx_ready);
  assign fifo_in   = ack_req ? ACK_BYTE : rx_data;

  midi_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (fifo_push),
    .push_data (fifo_in),
    .pop       (data_rd),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (cfg_we) active_q <= cfg_activate;
      if ((rx_valid && !rx_ready) || (ack_req && fifo_full)) ovf_q <= 1'b1;
    end
  end

  assign rx_overflow = ovf_q;
  assign irq         = active_q && !fifo_empty;

  always_comb begin
    if (loc_e'(bus_addr) == LOC_CTRL)
      bus_rdata = {fifo_empty, busy, 6'b0};
    else
      bus_rdata = fifo_empty ? 8'h00 : fifo_head;
  end

  p_ack_push_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata == CMD_RESET && !fifo_full) |=> !fifo_empty);

  p_irq_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q) && $fell(irq)) |-> $past(data_rd));
endmodule

// File: tb/sim_midi_host_port.sv
`timescale 1ns/1ps
module sim_midi_host_port;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cfg_we = 1'b0, cfg_activate = 1'b0;
  logic       irq, tx_valid, rx_ready, rx_overflow, cmd_uart_mode;
  logic       tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic [7:0] rx_data = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  midi_host_port #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_we(cfg_we),
    .cfg_activate(cfg_activate), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_overflow(rx_overflow),
    .cmd_uart_mode(cmd_uart_mode)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIFO-port FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_active(input logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_activate = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(1'b1, v);
    check("R11 status", v, 8'h80);
    check("R2 reserved bits", {2'b0, v[5:0]}, 8'h00);
    check("R11 irq/tx_valid/ovf/mode",
          {4'b0, irq, tx_valid, rx_overflow, cmd_uart_mode}, 8'h00);
    check("R11 rx_ready", {7'b0, rx_ready}, 8'h01);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    set_active(1'b1);
    rx_send(8'h31);
    check("R7 irq after rx byte", {7'b0, irq}, 8'h01);
    bus_write(1'b0, 8'h55);
    check("R1 tx_valid after write", {7'b0, tx_valid}, 8'h01);
    check("R9 irq after tx write", {7'b0, irq}, 8'h01);
    peek(1'b1, v);
    check("R1 busy status (R3 data present)", v, 8'h40);
    bus_write(1'b0, 8'h66);
    check("R1 write while busy ignored", tx_data, 8'h55);
    bus_write(1'b1, 8'hFF);
    peek(1'b1, v);
    check("R1 command while busy ignored", v, 8'h40);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R1 tx_valid after handshake", {7'b0, tx_valid}, 8'h00);
    check("R9 irq after handshake", {7'b0, irq}, 8'h01);
    bus_read(1'b0, v);
    check("R6 data byte", v, 8'h31);
    check("R7 irq after last read", {7'b0, irq}, 8'h00);
    peek(1'b1, v);
    check("R3 status empty, R1 not busy", v, 8'h80);
  endtask

  task automatic t_cmd();
    logic [7:0] v;
    bus_write(1'b1, 8'h3F);
    check("R5 uart mode set", {7'b0, cmd_uart_mode}, 8'h01);
    check("R4 no tx for command", {7'b0, tx_valid}, 8'h00);
    check("R7 irq on ack", {7'b0, irq}, 8'h01);
    peek(1'b1, v);
    check("R3 status ack waiting", v, 8'h00);
    bus_read(1'b0, v);
    check("R5 ack byte", v, 8'hFE);
    bus_write(1'b1, 8'h3F);
    bus_write(1'b1, 8'h12);
    peek(1'b1, v);
    check("R5 no ack in uart mode", v, 8'h80);
    bus_write(1'b1, 8'hFF);
    check("R4 mode cleared", {7'b0, cmd_uart_mode}, 8'h00);
    bus_read(1'b0, v);
    check("R4 reset ack byte", v, 8'hFE);
    check("R4 no tx for reset", {7'b0, tx_valid}, 8'h00);
  endtask

  task automatic t_order();
    logic [7:0] v;
    rx_send(8'hA1); rx_send(8'hA2); rx_send(8'hA3);
    bus_read(1'b0, v); check("R6 first", v, 8'hA1);
    check("R7 irq held after read", {7'b0, irq}, 8'h01);
    bus_read(1'b0, v); check("R6 second", v, 8'hA2);
    check("R7 irq held after second read", {7'b0, irq}, 8'h01);
    bus_read(1'b0, v); check("R6 third", v, 8'hA3);
    check("R7 irq low when empty", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    set_active(1'b0);
    rx_send(8'h77);
    check("R8 irq gated", {7'b0, irq}, 8'h00);
    set_active(1'b1);
    check("R8 irq after activate", {7'b0, irq}, 8'h01);
    bus_read(1'b0, v);
    check("R6 gated byte", v, 8'h77);
  endtask

  task automatic t_full();
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) rx_send(8'hB0 + 8'(i));
    check("R10 rx_ready low when full", {7'b0, rx_ready}, 8'h00);
    check("R10 no overflow yet", {7'b0, rx_overflow}, 8'h00);
    rx_send(8'hEE);
    check("R10 overflow set", {7'b0, rx_overflow}, 8'h01);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(1'b0, v);
      check("R10 kept byte", v, 8'hB0 + 8'(i));
    end
    peek(1'b1, v);
    check("R10 dropped byte absent", v, 8'h80);
    bus_read(1'b0, v);
    check("R12 empty read", v, 8'h00);
    peek(1'b1, v);
    check("R12 status unchanged", v, 8'h80);
    check("R10 overflow sticky", {7'b0, rx_overflow}, 8'h01);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    @(negedge clk);
    bus_addr = 1'b1; bus_wdata = 8'hFF; bus_wr = 1'b1;
    rx_valid = 1'b1; rx_data = 8'h5A;
    #1 check("R10 rx_ready low during ack", {7'b0, rx_ready}, 8'h00);
    @(negedge clk);
    bus_wr = 1'b0; rx_valid = 1'b0;
    bus_read(1'b0, v);
    check("R10 ack took slot", v, 8'hFE);
    peek(1'b1, v);
    check("R10 rx byte dropped", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx();
    t_cmd();
    t_order();
    t_gate();
    t_full();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule